// File: doc/BRIEF.md
# Ethernet receive status word builder

This block sits beside a MAC receive path and assembles the 32-bit status word that is written back into each receive descriptor. It follows one frame at a time, delivered as a byte stream qualified by a valid strobe, with start-of-frame and end-of-frame markers. Result strobes from the CRC checker, the address filter, the IP header checker, the receive watchdog and the overflow logic arrive as single-cycle pulses at any time during the frame and are held until the frame closes.

Each descriptor offers two buffers. Their combined size is the descriptor's capacity. The block counts the bytes that fall into the current descriptor. A descriptor closes when it fills, or when the frame ends. If a descriptor must close in mid-frame while the next one is not owned by the DMA, the frame is cut short there. The block also captures the Length/Type field and counts the frame's bytes, so that it can tell type frames from length frames and flag length mismatches. A status word leaves the block with a one-cycle valid strobe for every descriptor that closes.

Top module: `rx_status_builder`

## Requirements
- R1: A status word appears on `stat_word` together with a one-cycle `stat_valid`, one clock after the rising edge that sampled the byte (or the watchdog strobe) that closed the descriptor. While `stat_valid` is low, and during reset, `stat_word` is zero.
- R2: In a last descriptor, bit 15 is set when any of bits 1, 3, 4, 6, 11 or 14 is set, or when a giant frame was reported and no IP header checksum error was reported. A checksum error alone does not set bit 15.
- R3: A descriptor that is not the last of its frame carries only bit 9. Bits 15 and 14, and every other flag, read zero in it.
- R4: When a descriptor fills in mid-frame and `next_owned` is low, that descriptor closes with bits 8, 14 and 15 set. The rest of the frame up to the next start is ignored. Its bytes produce no status, and its error strobes do not reach any later word.
- R5: Bit 5 is set when frame bytes 12 and 13 (byte 12 the high half) form a value of at least 0x0600. It stays clear for frames shorter than 14 bytes.
- R6: Bit 12 is set when bit 5 is clear, the frame has at least 14 bytes, and the byte count minus 18 (14 header bytes plus a 4-byte FCS) differs from the Length/Type value.
- R7: Bit 9 goes on the descriptor that holds the frame's first byte. The capacity of a descriptor is `buf1_size + buf2_size`, so an empty buffer 1 moves the start into buffer 2. A descriptor whose capacity is zero closes without bit 9 on the byte that meets it, and that byte is carried into the next descriptor.
- R8: A descriptor closes without bit 8 on the byte that brings its count up to its capacity, unless that byte ends the frame. The closing byte of the frame always produces a status with bit 8 set, even when it also fills the descriptor exactly.
- R9: A watchdog strobe during a frame closes the current descriptor as the last one, with bits 4, 8 and 15 set. The frame is truncated at that point.
- R10: In a last descriptor the held strobes map to these bits: CRC error 1, receive error 3, late collision 6, giant frame or IP header checksum error 7, VLAN tag 10, overflow 11, source-address filter failure 13. Bits 0, 2 and 31 to 16 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A frame byte is present on `rx_byte` |
| rx_first | input | 1 | Marks the first byte of a frame (with `rx_valid`) |
| rx_last | input | 1 | Marks the final byte of a frame (with `rx_valid`) |
| rx_byte | input | 8 | Frame byte |
| crc_bad | input | 1 | CRC check failed |
| phy_err | input | 1 | Receive error signalled by the PHY |
| wdog_expired | input | 1 | Receive watchdog expired; ends the frame |
| late_coll | input | 1 | Late collision (half duplex) |
| too_long | input | 1 | Giant frame |
| ip_hdr_bad | input | 1 | IP header checksum error |
| vlan_seen | input | 1 | Frame carries a VLAN tag |
| sa_reject | input | 1 | Source-address filter failed |
| fifo_ovf | input | 1 | Receive buffer overflow |
| buf1_size | input | BUF_W | Size of buffer 1 of the current descriptor |
| buf2_size | input | BUF_W | Size of buffer 2 of the current descriptor |
| next_owned | input | 1 | The next descriptor belongs to the DMA |
| stat_valid | output | 1 | One-cycle strobe: a descriptor closed |
| stat_word | output | 32 | Descriptor status word |

## Verification
Every status word is registered once, so it is due exactly one clock after the edge that sampled the byte or watchdog strobe that closed its descriptor. That applies whether the close came from a full descriptor, a skipped zero-capacity descriptor, a truncation or the frame end. The bench drives inputs on falling edges and logs the drive cycle of every byte. A monitor, also on falling edges, logs each `stat_valid` with its cycle number. Each check then compares both the word and its arrival cycle with the drive cycle of the closing byte plus one. After a truncation or a watchdog close, the bench also checks that nothing more arrives, and it uses the next frame's word to show that ignored strobes left no trace.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // Held event flags for one frame.
  typedef struct packed {
    logic saf;
    logic vlan;
    logic ovf;
    logic ipc;
    logic giant;
    logic lco;
    logic wdog;
    logic rxe;
    logic crc;
  } rx_err_t;

  // Status word bit positions.
  localparam int unsigned B_CRC  = 1;
  localparam int unsigned B_RXE  = 3;
  localparam int unsigned B_WDOG = 4;
  localparam int unsigned B_FT   = 5;
  localparam int unsigned B_LCO  = 6;
  localparam int unsigned B_B7   = 7;
  localparam int unsigned B_LS   = 8;
  localparam int unsigned B_FS   = 9;
  localparam int unsigned B_VLAN = 10;
  localparam int unsigned B_OVF  = 11;
  localparam int unsigned B_LE   = 12;
  localparam int unsigned B_SAF  = 13;
  localparam int unsigned B_DE   = 14;
  localparam int unsigned B_ES   = 15;

  // Frame layout.
  localparam int unsigned LT_POS    = 12;
  localparam int unsigned HDR_BYTES = 14;
  localparam int unsigned FCS_BYTES = 4;
  localparam logic [15:0] ETYPE_MIN = 16'h0600;

endpackage

// File: rtl/rxs_err_collect.sv
module rxs_err_collect
  import rxs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    active,
  input  rx_err_t strobes,
  output rx_err_t held
);

  rx_err_t err_q;
  rx_err_t err_d;

  // Flags seen so far in this frame, including this cycle's strobes.
  always_comb begin
    err_d = start ? '0 : err_q;
    if (active) begin
      err_d = err_d | strobes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (active) begin
      err_q <= err_d;
    end
  end

  assign held = err_d;

endmodule

// File: rtl/rxs_frame_track.sv
module rxs_frame_track
  import rxs_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       byte_en,
  input  logic [7:0] data,
  output logic       ft,
  output logic       le
);

  localparam int unsigned EXT_W = CNT_W + 1;
  localparam int unsigned OVERHEAD = HDR_BYTES + FCS_BYTES;

  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic [15:0]      lt_q, lt_base, lt_d;
  logic [EXT_W-1:0] cnt_ext, lt_ext;
  logic             long_enough;

  always_comb begin
    cnt_base = start ? '0 : cnt_q;
    lt_base  = start ? '0 : lt_q;
    cnt_d    = cnt_base + {{(CNT_W-1){1'b0}}, byte_en};
    lt_d     = lt_base;
    if (byte_en && (cnt_base == CNT_W'(LT_POS))) begin
      lt_d[15:8] = data;
    end
    if (byte_en && (cnt_base == CNT_W'(LT_POS + 1))) begin
      lt_d[7:0] = data;
    end
  end

  // Classification on the byte count including this cycle's byte.
  always_comb begin
    long_enough = (cnt_d >= CNT_W'(HDR_BYTES));
    cnt_ext     = {1'b0, cnt_d};
    lt_ext      = EXT_W'(lt_d) + EXT_W'(OVERHEAD);
    ft          = long_enough && (lt_d >= ETYPE_MIN);
    le          = long_enough && !ft && (cnt_ext != lt_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lt_q  <= '0;
    end else if (byte_en) begin
      cnt_q <= cnt_d;
      lt_q  <= lt_d;
    end
  end

endmodule

// File: rtl/rxs_desc_fill.sv
module rxs_desc_fill #(
  parameter int unsigned BUF_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_first,
  input  logic             rx_last,
  input  logic             wdog,
  input  logic [BUF_W-1:0] buf1_size,
  input  logic [BUF_W-1:0] buf2_size,
  input  logic             next_owned,
  output logic             start,
  output logic             active,
  output logic             byte_en,
  output logic             close,
  output logic             last,
  output logic             trunc,
  output logic             fs
);

  localparam int unsigned CAP_W = BUF_W + 1;

  logic             in_frame_q, in_frame_d;
  logic             fp_q, fp_d, fp_base;
  logic [CAP_W-1:0] fill_q, fill_d, fill_base, fill_inc, cap;
  logic             end_evt, skip, full, mid, placed;

  always_comb begin
    start     = rx_valid && rx_first;
    active    = in_frame_q || start;
    byte_en   = rx_valid && active;
    end_evt   = active && ((byte_en && rx_last) || wdog);
    cap       = CAP_W'(buf1_size) + CAP_W'(buf2_size);
    fill_base = start ? '0 : fill_q;
    fp_base   = start || fp_q;
    skip      = byte_en && (cap == '0) && !end_evt;
    placed    = byte_en && !skip;
    fill_inc  = fill_base + {{(CAP_W-1){1'b0}}, placed};
    full      = placed && !end_evt && (fill_inc >= cap);
    mid       = skip || full;
    close     = end_evt || mid;
    trunc     = mid && !next_owned;
    last      = end_evt || trunc;
    fs        = fp_base && ((fill_base != '0) || placed);
  end

  always_comb begin
    in_frame_d = in_frame_q;
    fill_d     = fill_q;
    fp_d       = fp_q;
    if (close && last) begin
      in_frame_d = 1'b0;
      fill_d     = '0;
      fp_d       = 1'b0;
    end else if (mid) begin
      in_frame_d = 1'b1;
      fill_d     = skip ? {{(CAP_W-1){1'b0}}, 1'b1} : '0;
      fp_d       = skip && fp_base;
    end else if (active) begin
      in_frame_d = 1'b1;
      fill_d     = fill_inc;
      fp_d       = fp_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      fill_q     <= '0;
      fp_q       <= 1'b0;
    end else if (active) begin
      in_frame_q <= in_frame_d;
      fill_q     <= fill_d;
      fp_q       <= fp_d;
    end
  end

endmodule

// File: rtl/rx_status_builder.sv
module rx_status_builder
  import rxs_pkg::*;
#(
  parameter int unsigned BUF_W = 14,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_first,
  input  logic             rx_last,
  input  logic [7:0]       rx_byte,
  input  logic             crc_bad,
  input  logic             phy_err,
  input  logic             wdog_expired,
  input  logic             late_coll,
  input  logic             too_long,
  input  logic             ip_hdr_bad,
  input  logic             vlan_seen,
  input  logic             sa_reject,
  input  logic             fifo_ovf,
  input  logic [BUF_W-1:0] buf1_size,
  input  logic [BUF_W-1:0] buf2_size,
  input  logic             next_owned,
  output logic             stat_valid,
  output logic [31:0]      stat_word
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       start, active, byte_en, close, last, trunc, fs, ft, le;
  rx_err_t    strobes, held;
  logic [31:0] word_d;
  logic        valid_q;
  logic [31:0] word_q;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    strobes       = '0;
    strobes.crc   = crc_bad;
    strobes.rxe   = phy_err;
    strobes.wdog  = wdog_expired;
    strobes.lco   = late_coll;
    strobes.giant = too_long;
    strobes.ipc   = ip_hdr_bad;
    strobes.vlan  = vlan_seen;
    strobes.saf   = sa_reject;
    strobes.ovf   = fifo_ovf;
  end

  rxs_desc_fill #(.BUF_W(BUF_W)) u_fill (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_valid  (rx_valid),
    .rx_first  (rx_first),
    .rx_last   (rx_last),
    .wdog      (wdog_expired),
    .buf1_size (buf1_size),
    .buf2_size (buf2_size),
    .next_owned(next_owned),
    .start     (start),
    .active    (active),
    .byte_en   (byte_en),
    .close     (close),
    .last      (last),
    .trunc     (trunc),
    .fs        (fs)
  );

  rxs_frame_track #(.CNT_W(CNT_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .byte_en(byte_en),
    .data   (rx_byte),
    .ft     (ft),
    .le     (le)
  );

  rxs_err_collect u_err (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .active (active),
    .strobes(strobes),
    .held   (held)
  );

  // Compose the word of the descriptor that closes in this cycle.
  always_comb begin
    word_d = '0;
    if (close) begin
      word_d[B_FS] = fs;
      if (last) begin
        word_d[B_LS]   = 1'b1;
        word_d[B_CRC]  = held.crc;
        word_d[B_RXE]  = held.rxe;
        word_d[B_WDOG] = held.wdog;
        word_d[B_LCO]  = held.lco;
        word_d[B_B7]   = held.giant || held.ipc;
        word_d[B_VLAN] = held.vlan;
        word_d[B_OVF]  = held.ovf;
        word_d[B_SAF]  = held.saf;
        word_d[B_FT]   = ft;
        word_d[B_LE]   = le;
        word_d[B_DE]   = trunc;
        word_d[B_ES]   = held.crc || held.rxe || held.wdog || held.lco ||
                         (held.giant && !held.ipc) || held.ovf || trunc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= close;
      word_q  <= word_d;
    end
  end

  assign stat_valid = valid_q;
  assign stat_word  = word_q;

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        stat_valid,
  input logic [31:0] stat_word
);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> (stat_word == 32'h0));

  p_es_sources_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[8] &&
     (stat_word[1] || stat_word[3] || stat_word[4] || stat_word[6] ||
      stat_word[11] || stat_word[14])) |-> stat_word[15]);

  p_mid_fs_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_word[8]) |-> ((stat_word & ~32'h0000_0200) == 32'h0));

  p_de_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[14]) |-> (stat_word[8] && stat_word[15]));

  p_type_no_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[5]) |-> !stat_word[12]);

  p_wdog_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[4]) |-> (stat_word[8] && stat_word[15]));

  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ((stat_word[31:16] == 16'h0) && !stat_word[0] && !stat_word[2]));

endmodule

bind rx_status_builder rxs_checker u_rxs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_valid(stat_valid),
  .stat_word (stat_word)
);

// File: tb/rx_status_builder_bench.sv
module rx_status_builder_bench;

  localparam int unsigned BUF_W = 14;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] lt;
    logic [7:0]  errs;   // 0 crc,1 phy,2 lcoll,3 giant,4 iphdr,5 vlan,6 sa,7 ovf
    logic [15:0] b1;
    logic [15:0] b2;
    logic        ft;
    logic        le;
    logic        es;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{len:16'd64, lt:16'h0800, errs:8'h00, b1:16'd40,  b2:16'd24, ft:1'b1, le:1'b0, es:1'b0},
    '{len:16'd64, lt:16'h002E, errs:8'h00, b1:16'd100, b2:16'd28, ft:1'b0, le:1'b0, es:1'b0},
    '{len:16'd64, lt:16'h0028, errs:8'h00, b1:16'd100, b2:16'd28, ft:1'b0, le:1'b1, es:1'b0},
    '{len:16'd60, lt:16'h0600, errs:8'h01, b1:16'd100, b2:16'd28, ft:1'b1, le:1'b0, es:1'b1},
    '{len:16'd10, lt:16'h0000, errs:8'h02, b1:16'd100, b2:16'd28, ft:1'b0, le:1'b0, es:1'b1},
    '{len:16'd70, lt:16'h0800, errs:8'h10, b1:16'd100, b2:16'd28, ft:1'b1, le:1'b0, es:1'b0},
    '{len:16'd70, lt:16'h0800, errs:8'h08, b1:16'd100, b2:16'd28, ft:1'b1, le:1'b0, es:1'b1},
    '{len:16'd64, lt:16'h05FF, errs:8'h60, b1:16'd100, b2:16'd28, ft:1'b0, le:1'b1, es:1'b0},
    '{len:16'd80, lt:16'h86DD, errs:8'h84, b1:16'd100, b2:16'd28, ft:1'b1, le:1'b0, es:1'b1}
  };

  logic             clk, rst_n;
  logic             rx_valid, rx_first, rx_last;
  logic [7:0]       rx_byte;
  logic             crc_bad, phy_err, wdog_expired, late_coll, too_long;
  logic             ip_hdr_bad, vlan_seen, sa_reject, fifo_ovf;
  logic [BUF_W-1:0] buf1_size, buf2_size;
  logic             next_owned;
  logic             stat_valid;
  logic [31:0]      stat_word;

  int          n_chk, n_err, cyc, n_got;
  logic [31:0] got_word [16];
  int          got_cyc  [16];
  int          byte_cyc [256];
  bit          done;

  rx_status_builder #(.BUF_W(BUF_W), .CNT_W(16)) u_rx_status_builder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_last(rx_last), .rx_byte(rx_byte), .crc_bad(crc_bad), .phy_err(phy_err),
    .wdog_expired(wdog_expired), .late_coll(late_coll), .too_long(too_long),
    .ip_hdr_bad(ip_hdr_bad), .vlan_seen(vlan_seen), .sa_reject(sa_reject),
    .fifo_ovf(fifo_ovf), .buf1_size(buf1_size), .buf2_size(buf2_size),
    .next_owned(next_owned), .stat_valid(stat_valid), .stat_word(stat_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Log every status word with the cycle it was seen in.
  always @(negedge clk) begin
    if (stat_valid && n_got < 16) begin
      got_word[n_got] = stat_word;
      got_cyc[n_got]  = cyc;
      n_got = n_got + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_last(input logic [7:0] e, input logic fs,
      input logic ft, input logic le, input logic wd, input logic de, input logic es);
    logic [31:0] w;
    w = '0;
    w[8]  = 1'b1;     w[9]  = fs;
    w[1]  = e[0];     w[3]  = e[1];   w[6] = e[2];
    w[7]  = e[3] | e[4];
    w[10] = e[5];     w[13] = e[6];   w[11] = e[7];
    w[5]  = ft;       w[12] = le;     w[4] = wd;
    w[14] = de;       w[15] = es;
    return w;
  endfunction

  task automatic idle_inputs();
    rx_valid = 0; rx_first = 0; rx_last = 0; rx_byte = 0;
    crc_bad = 0; phy_err = 0; wdog_expired = 0; late_coll = 0; too_long = 0;
    ip_hdr_bad = 0; vlan_seen = 0; sa_reject = 0; fifo_ovf = 0;
  endtask

  task automatic send_frame(input int len, input logic [15:0] lt, input logic [7:0] errs,
      input int err_at, input int wd_at, input int b1, input int b2,
      input logic own, input bit zero_first);
    n_got = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      idle_inputs();
      rx_valid   = 1;
      rx_first   = (i == 0);
      rx_last    = (i == len - 1);
      rx_byte    = (i == 12) ? lt[15:8] : (i == 13) ? lt[7:0] : 8'(i + 1);
      next_owned = own;
      buf1_size  = (zero_first && i == 0) ? '0 : BUF_W'(b1);
      buf2_size  = (zero_first && i == 0) ? '0 : BUF_W'(b2);
      if (i == err_at) begin
        {fifo_ovf, sa_reject, vlan_seen, ip_hdr_bad, too_long, late_coll, phy_err, crc_bad} = errs;
      end
      wdog_expired = (i == wd_at);
      byte_cyc[i]  = cyc;
    end
    @(negedge clk);
    idle_inputs();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; n_got = 0; done = 0;
    idle_inputs();
    buf1_size = '0; buf2_size = '0; next_owned = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(stat_valid), 32'h0);
    chk("R1 reset word", stat_word, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", 32'(stat_valid), 32'h0);

    // Table: single-descriptor frames (R2, R5, R6, R8, R10).
    for (int v = 0; v < 9; v++) begin
      send_frame(int'(VECS[v].len), VECS[v].lt, VECS[v].errs, 5, -1,
                 int'(VECS[v].b1), int'(VECS[v].b2), 1'b1, 1'b0);
      chk($sformatf("R8 vec%0d count", v), 32'(n_got), 32'd1);
      chk($sformatf("R10 R2 R5 R6 vec%0d word", v), got_word[0],
          exp_last(VECS[v].errs, 1'b1, VECS[v].ft, VECS[v].le, 1'b0, 1'b0, VECS[v].es));
      chk($sformatf("R1 vec%0d timing", v), 32'(got_cyc[0]),
          32'(byte_cyc[int'(VECS[v].len) - 1] + 1));
    end

    // Frame over three descriptors of 16 bytes (R3, R7, R8).
    send_frame(40, 16'h0800, 8'h01, 3, -1, 8, 8, 1'b1, 1'b0);
    chk("R8 multi count", 32'(n_got), 32'd3);
    chk("R7 R3 first desc", got_word[0], 32'h0000_0200);
    chk("R1 first desc timing", 32'(got_cyc[0]), 32'(byte_cyc[15] + 1));
    chk("R3 middle desc", got_word[1], 32'h0000_0000);
    chk("R1 middle timing", 32'(got_cyc[1]), 32'(byte_cyc[31] + 1));
    chk("R3 R2 last desc", got_word[2], 32'h0000_8122);

    // Zero-capacity descriptor skipped, frame starts in buffer 2 (R7).
    send_frame(20, 16'h0002, 8'h00, -1, -1, 0, 64, 1'b1, 1'b1);
    chk("R7 skip count", 32'(n_got), 32'd2);
    chk("R7 skipped desc", got_word[0], 32'h0000_0000);
    chk("R7 skip timing", 32'(got_cyc[0]), 32'(byte_cyc[0] + 1));
    chk("R7 R6 start desc", got_word[1], 32'h0000_0300);

    // Truncation when the next descriptor is not owned (R4).
    send_frame(30, 16'h0800, 8'h01, 20, -1, 8, 0, 1'b0, 1'b0);
    chk("R4 trunc count", 32'(n_got), 32'd1);
    chk("R4 trunc word", got_word[0], 32'h0000_C300);
    chk("R4 trunc timing", 32'(got_cyc[0]), 32'(byte_cyc[7] + 1));
    send_frame(64, 16'h0800, 8'h00, -1, -1, 100, 28, 1'b1, 1'b0);
    chk("R4 ignored strobe left no trace", got_word[0], 32'h0000_0320);

    // Watchdog truncation (R9).
    send_frame(40, 16'h0800, 8'h00, -1, 20, 100, 28, 1'b1, 1'b0);
    chk("R9 wdog count", 32'(n_got), 32'd1);
    chk("R9 wdog word", got_word[0], 32'h0000_8330);
    chk("R9 wdog timing", 32'(got_cyc[0]), 32'(byte_cyc[20] + 1));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule